// File: doc/BRIEF.md
# AES-256 Key Schedule Step Engine

This block advances an AES-256 key schedule by one round key. The caller hands it two vector operands, each holding several 4-word element groups, along with a 5-bit round number. In every group, the destination operand supplies the older round key and the source operand supplies the newer one. The block then writes the following round key back over the destination group. Each 32-bit element is byte-reversed on the way in and again on the way out, so the key-schedule arithmetic runs on big-endian words.

A request is accepted through a valid/ready handshake. The request carries both operands, the round number, a start element index, an active length in elements, a tail policy and a flag that says whether the element width is 32 bits. The engine handles one group per clock, starting at the group that holds the start index and stopping below the group count set by the length. In a final cycle it applies the tail policy and pulses `done_o`. A start index that is not a multiple of four, or an element width other than 32, is flagged as illegal and leaves the destination as it was.

Top module: `aes256_kexp_vec`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0, `illegal_o` is 0 and `res_o` is all zeros.
- R2: Only bits 3:0 of `rnd_i` are used. When that value is below 2 or above 14, bit 3 is inverted; the result is the round number r.
- R3: For even r, word 0 of the new key is old word 0 XOR SubWord of the last source word rotated left by one byte, XOR a round constant 0x01 shifted left by (r-1)/2, placed in the top byte.
- R4: For odd r, word 0 of the new key is old word 0 XOR SubWord of the last source word, with no rotation and no constant.
- R5: New words 1 to 3 each equal the old destination word at the same position XOR the new word just before it. Old words and new words are both taken as the byte-reversed 32-bit elements, with element 4g+j at bits [(4g+j)*32 +: 32].
- R6: Groups from start_i/4 up to (but not including) min(len_i/4, NUM_GRP) are rewritten one per cycle, the first one cycle after acceptance. `done_o` pulses for a single cycle, one cycle after the last group is written, and `ready_o` returns in that same cycle.
- R7: With `tail_ones_i` set, every element at index len_i or above is set to all ones when `done_o` pulses. With it clear, those elements keep their destination values.
- R8: If start_i mod 4 is not 0, or `sew32_i` is 0, no group is rewritten and no tail fill takes place. `illegal_o` rises together with `done_o`, and `res_o` equals `dst_i`.
- R9: While a request is in progress, `ready_o` is 0 and a valid request is ignored.
- R10: Groups below the start group keep their destination values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request valid |
| ready_o | output | 1 | Engine idle, request accepted |
| dst_i | input | NE*32 | Destination operand (older round key per group) |
| src_i | input | NE*32 | Source operand (newer round key per group) |
| rnd_i | input | 5 | Round number immediate |
| start_i | input | IW | Start element index |
| len_i | input | IW | Active length in elements |
| tail_ones_i | input | 1 | Tail-agnostic: fill tail with ones |
| sew32_i | input | 1 | Element width is 32 bits |
| res_o | output | NE*32 | Result vector (destination after update) |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Last request had an illegal configuration |

## Verification
Each group is loaded with a consecutive pair of round keys, taken from the full standard AES-256 expansion of a distinct key; group 0 uses the 00..1f test key. Each output group is compared with the next round key from that same expansion. Even and odd rounds, the rounds at the ends of the range (2, 13, 14) and out-of-range immediates that wrap through bit 3 are all exercised, so a fault in the rotation, the substitution, the round constant or the remap rule shows up as a wrong word. Start and length values that are partial or offset separate the start bound, the group floor of the length and element-level tail fill. Misaligned starts and the wrong element width are checked for unchanged data, and a request that arrives mid-operation must leave the result alone.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned GRP_ELEMS = 4;
  localparam int unsigned GRP_W     = WORD_W * GRP_ELEMS;

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} kx_state_e;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // inverse as x^254 = product of x^(2^k), k=1..7
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] sq, inv;
    sq  = x;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [3:0] norm_rnd(input logic [4:0] imm);
    logic [3:0] m;
    m = imm[3:0];
    if (m < 4'd2 || m > 4'd14) m[3] = ~m[3];
    return m;
  endfunction
endpackage

// File: rtl/aes_kx_sbox.sv
module aes_kx_sbox
  import aes_kx_pkg::*;
(
  input  logic [7:0] in_i,
  output logic [7:0] out_o
);
  always_comb out_o = sbox_calc(in_i);
endmodule

// File: rtl/aes_kx_step.sv
module aes_kx_step
  import aes_kx_pkg::*;
(
  input  logic [GRP_W-1:0]  prev_i,  // word0 at top, big-endian words
  input  logic [WORD_W-1:0] last_i,
  input  logic [3:0]        rnd_i,
  output logic [GRP_W-1:0]  next_o
);
  logic [WORD_W-1:0] sub_w, tmp_w, n0, n1, n2, n3;
  logic [7:0]        rcon;

  for (genvar b = 0; b < 4; b++) begin : g_sb
    aes_kx_sbox u_sb (.in_i(last_i[b*8 +: 8]), .out_o(sub_w[b*8 +: 8]));
  end

  always_comb begin
    rcon = 8'h01 << ((rnd_i - 4'd1) >> 1);
    if (!rnd_i[0]) tmp_w = {sub_w[23:0], sub_w[31:24]} ^ {rcon, 24'h0};
    else           tmp_w = sub_w;
    n0 = prev_i[127:96] ^ tmp_w;
    n1 = prev_i[95:64]  ^ n0;
    n2 = prev_i[63:32]  ^ n1;
    n3 = prev_i[31:0]   ^ n2;
    next_o = {n0, n1, n2, n3};
  end
endmodule

// File: rtl/aes256_kexp_vec.sv
module aes256_kexp_vec
  import aes_kx_pkg::*;
#(
  parameter int unsigned NUM_GRP = 4,
  localparam int unsigned NE     = NUM_GRP * GRP_ELEMS,
  localparam int unsigned BUS_W  = NE * WORD_W,
  localparam int unsigned IW     = $clog2(NE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [BUS_W-1:0] dst_i,
  input  logic [BUS_W-1:0] src_i,
  input  logic [4:0]       rnd_i,
  input  logic [IW-1:0]    start_i,
  input  logic [IW-1:0]    len_i,
  input  logic             tail_ones_i,
  input  logic             sew32_i,
  output logic [BUS_W-1:0] res_o,
  output logic             done_o,
  output logic             illegal_o
);
  localparam int unsigned GIX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  kx_state_e        state_q;
  logic [BUS_W-1:0] res_q, src_q;
  logic [3:0]       rnd_q;
  logic [IW-1:0]    cur_q, end_q, len_q;
  logic             tail_q, ill_q, done_q, ill_out_q;

  logic             legal;
  logic [IW-1:0]    sg_w, eg_w;
  logic [GIX_W-1:0] cur_idx;
  logic [GRP_W-1:0] grp_old, grp_src, prev_be, next_be, grp_new;

  always_comb begin
    legal = (start_i[1:0] == 2'b00) && sew32_i;
    sg_w  = start_i >> 2;
    eg_w  = ((len_i >> 2) > IW'(NUM_GRP)) ? IW'(NUM_GRP) : (len_i >> 2);
  end

  assign cur_idx = cur_q[GIX_W-1:0];
  assign grp_old = res_q[cur_idx*GRP_W +: GRP_W];
  assign grp_src = src_q[cur_idx*GRP_W +: GRP_W];

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      prev_be[(3-j)*WORD_W +: WORD_W] = bswap32(grp_old[j*WORD_W +: WORD_W]);
      grp_new[j*WORD_W +: WORD_W]     = bswap32(next_be[(3-j)*WORD_W +: WORD_W]);
    end
  end

  aes_kx_step u_step (
    .prev_i (prev_be),
    .last_i (bswap32(grp_src[3*WORD_W +: WORD_W])),
    .rnd_i  (rnd_q),
    .next_o (next_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      res_q     <= '0;
      src_q     <= '0;
      rnd_q     <= 4'd2;
      cur_q     <= '0;
      end_q     <= '0;
      len_q     <= '0;
      tail_q    <= 1'b0;
      ill_q     <= 1'b0;
      done_q    <= 1'b0;
      ill_out_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (valid_i) begin
          res_q     <= dst_i;
          src_q     <= src_i;
          rnd_q     <= norm_rnd(rnd_i);
          len_q     <= len_i;
          tail_q    <= tail_ones_i;
          ill_q     <= !legal;
          ill_out_q <= 1'b0;
          // illegal or empty range: no group is written
          if (!legal || sg_w >= eg_w) begin
            cur_q <= '0;
            end_q <= '0;
          end else begin
            cur_q <= sg_w;
            end_q <= eg_w;
          end
          state_q <= ST_RUN;
        end
        default: begin
          if (cur_q < end_q) begin
            res_q[cur_idx*GRP_W +: GRP_W] <= grp_new;
            cur_q <= cur_q + 1'b1;
          end else begin
            for (int e = 0; e < int'(NE); e++)
              if (tail_q && !ill_q && e >= int'(len_q)) res_q[e*WORD_W +: WORD_W] <= '1;
            done_q    <= 1'b1;
            ill_out_q <= ill_q;
            state_q   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign res_o     = res_q;
  assign done_o    = done_q;
  assign illegal_o = ill_out_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  // R6
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> ready_o);
  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i && ready_o |=> !ready_o);
  // R8
  ill_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(illegal_o) |-> done_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) ready_o && !valid_i |=> $stable(res_o));
  // R2
  rnd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !ready_o |-> (rnd_q >= 4'd2 && rnd_q <= 4'd14));
endmodule

// File: tb/tb_aes256_kexp_vec.sv
module tb_aes256_kexp_vec;
  localparam int NG = 4;
  localparam int NE = NG * 4;
  localparam int BW = NE * 32;
  localparam int IW = $clog2(NE + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          valid = 1'b0, tail = 1'b0, sew = 1'b1;
  logic [BW-1:0] dst = '0, src = '0;
  logic [4:0]    rnd = '0;
  logic [IW-1:0] start = '0, len = '0;
  logic [BW-1:0] res;
  logic          ready, done, ill;

  aes256_kexp_vec #(.NUM_GRP(NG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .dst_i(dst), .src_i(src), .rnd_i(rnd), .start_i(start), .len_i(len),
    .tail_ones_i(tail), .sew32_i(sew), .res_o(res), .done_o(done), .illegal_o(ill));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] ws [NG][60];

  function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sb(logic [7:0] x);
    logic [7:0] y = 0, r;
    for (int c = 1; c < 256; c++) if (bmul(x, 8'(c)) == 8'h01) y = 8'(c);
    r = 8'h63;
    for (int k = 0; k < 5; k++) r ^= (y << k) | (y >> (8 - k));
    return r;
  endfunction

  function automatic logic [31:0] subw(logic [31:0] w);
    return {sb(w[31:24]), sb(w[23:16]), sb(w[15:8]), sb(w[7:0])};
  endfunction

  function automatic logic [31:0] sw(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic expand(int g);
    logic [7:0] kb;
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 8; i++) begin
      t = 0;
      for (int b = 0; b < 4; b++) begin
        kb = (g == 0) ? 8'(4*i+b) : 8'((4*i+b)*7 + g*29 + 3);
        t = {t[23:0], kb};
      end
      ws[g][i] = t;
    end
    for (int i = 8; i < 60; i++) begin
      t = ws[g][i-1];
      if (i % 8 == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end else if (i % 8 == 4) t = subw(t);
      ws[g][i] = t ^ ws[g][i-8];
    end
  endtask

  task automatic chk(bit ok, string tag, logic [BW-1:0] got, logic [BW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic run_op(logic [4:0] imm, int st, int ln, bit tl, bit sw32, bit poke, string tag);
    int r, sg, eg, ng;
    bit leg;
    logic [BW-1:0] d, s, e;
    r = imm & 15;
    if (r < 2 || r > 14) r ^= 8;
    for (int g = 0; g < NG; g++)
      for (int j = 0; j < 4; j++) begin
        d[(4*g+j)*32 +: 32] = sw(ws[g][4*(r-2)+j]);
        s[(4*g+j)*32 +: 32] = sw(ws[g][4*(r-1)+j]);
      end
    leg = (st % 4 == 0) && sw32;
    sg = st / 4;
    eg = (ln / 4 > NG) ? NG : ln / 4;
    ng = (leg && eg > sg) ? eg - sg : 0;
    @(negedge clk);
    dst = d; src = s; rnd = imm; start = IW'(st); len = IW'(ln); tail = tl; sew = sw32; valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    for (int c = 0; c <= ng + 1; c++) begin
      if (c > 0) @(negedge clk);
      if (poke && c == 1) begin
        dst = ~d; src = ~s; rnd = 5'd3; start = '0; len = IW'(NE); valid = 1'b1;
      end
      if (poke && c == 2) valid = 1'b0;
      for (int el = 0; el < NE; el++) begin
        int g = el / 4;
        if (g >= sg && g < sg + ng && g < sg + c)
          e[el*32 +: 32] = sw(ws[g][4*r + el%4]);
        else if (c == ng + 1 && leg && tl && el >= ln)
          e[el*32 +: 32] = '1;
        else
          e[el*32 +: 32] = d[el*32 +: 32];
      end
      chk(res === e, $sformatf("%s res c=%0d", tag, c), res, e);
      chk(done === (c == ng + 1), $sformatf("R6 %s done c=%0d", tag, c), BW'(done), BW'(c == ng + 1));
      chk(ready === (c == ng + 1), $sformatf("R9 %s ready c=%0d", tag, c), BW'(ready), BW'(c == ng + 1));
      if (c == ng + 1) chk(ill === !leg, $sformatf("R8 %s illegal", tag), BW'(ill), BW'(!leg));
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got hang exp done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) expand(g);
    repeat (3) @(negedge clk);
    // R1
    chk(ready === 1'b1 && done === 1'b0 && ill === 1'b0 && res === '0, "R1 reset", res, '0);
    rst_n = 1'b1;
    run_op(5'd2,  0, 16, 0, 1, 1, "R3 R5 R9 even r2 busy-poke");
    run_op(5'd3,  0, 16, 0, 1, 0, "R4 R5 odd r3");
    run_op(5'd14, 0, 16, 1, 1, 0, "R3 r14");
    run_op(5'd13, 0, 16, 0, 1, 0, "R4 r13");
    run_op(5'd0,  0, 16, 0, 1, 0, "R2 imm0->8");
    run_op(5'd17, 0, 16, 0, 1, 0, "R2 imm17->9");
    run_op(5'd15, 0, 16, 0, 1, 0, "R2 imm15->7");
    run_op(5'd30, 0, 16, 0, 1, 0, "R2 imm30->14");
    run_op(5'd6,  4, 12, 1, 1, 0, "R10 R7 start4 len12 ones");
    run_op(5'd7,  0, 10, 1, 1, 0, "R6 R7 len10 ones");
    run_op(5'd8,  0, 8,  0, 1, 0, "R7 len8 undisturbed");
    run_op(5'd9,  12, 8, 1, 1, 0, "R6 R7 start past len");
    run_op(5'd4,  2, 16, 1, 1, 0, "R8 misaligned start");
    run_op(5'd5,  0, 16, 1, 0, 0, "R8 sew not 32");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule